// File: doc/BRIEF.md
# Reconfigurable Region Freeze Controller

This block sequences the safe retirement and start-up of a logic region whose contents are swapped while the rest of the chip keeps running. Software asks for a freeze through a small register interface. The controller then asks the hosted function to stop and waits for its acknowledge. Only after that acknowledge does it drive the freeze lines to every isolation bridge and report the region as frozen. While the region is frozen, the reconfiguration engine can replace the logic.

Software then asks for an unfreeze. The controller drops the freeze lines, asks the new function to start, and reports the region as running once the function acknowledges. A separate control bit sends a one-cycle reset pulse into the region. Each isolation bridge can report an illegal access. These reports are collected into per-bridge sticky flags, and a maskable level interrupt is raised while any enabled flag is set.

All logic runs on one clock with a synchronous, active-high reset. The register interface is word addressed: 2-bit address, separate read and write strobes, and 32-bit data buses.

Top module: `prr_freeze_ctrl`

## Requirements
- R1: After reset, the region is in the running state. The running status is 1. Frozen status, stop request, start request, all freeze lines, region reset, interrupt and read data are all 0.
- R2: In the running state, a write to word 1 with bit 0 set raises the stop request from the next cycle. The stop request stays high, with all freeze lines low, for as long as the stop acknowledge stays 0.
- R3: While the stop request is high, a stop acknowledge of 1 moves the block to the frozen state in the next cycle. In that state the stop request is low, every freeze line is high, and the frozen status is 1.
- R4: In the frozen state, a write to word 1 with bit 1 set drops every freeze line and raises the start request in the next cycle. The frozen status goes low in the same cycle.
- R5: While the start request is high, a start acknowledge of 1 returns the block to the running state in the next cycle. The start request goes low and the running status goes to 1.
- R6: A freeze request (word 1 bit 0) is ignored in every state but running. An unfreeze request (word 1 bit 1) is ignored in every state but frozen. When both bits are written together in the running state, only the freeze acts.
- R7: A write to word 1 with bit 2 set gives a region reset pulse of exactly one cycle, in the next cycle, whatever the sequencing state.
- R8: An illegal-access input of 1 on bridge i sets sticky bit i, which reads back as bit i of word 2. The bit stays set until a write to word 2 has a 1 in bit i. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: The interrupt is high exactly while some sticky bit i is set and interrupt-enable bit i is set. The enable bits are bit i of word 3, written directly and reset to 0.
- R10: A read returns data in the cycle after the read strobe, and the data bus is 0 in every other cycle. Word 0 holds frozen status in bit 0, running status in bit 1 and busy in bit 2. Word 1 reads as 0. Word 2 holds the sticky bits and word 3 the enable bits, in the low bits. All unused bits read as 0.
- R11: The busy bit in word 0 is 1 exactly while the stop request or the start request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 2 | Word address of the register access |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt for enabled illegal-access flags |
| stop_req | output | 1 | Asks the hosted function to stop |
| stop_ack | input | 1 | Hosted function has stopped |
| start_req | output | 1 | Asks the new function to start |
| start_ack | input | 1 | New function is running |
| region_rst | output | 1 | One-cycle reset pulse into the region |
| frz_status | output | 1 | Region is frozen |
| unfrz_status | output | 1 | Region is running and not frozen |
| bridge_freeze | output | NUM_BRIDGES | Freeze line to each isolation bridge |
| bridge_illegal | input | NUM_BRIDGES | Illegal-access report from each bridge |

## Verification
The hardest situations to reach from the ports are the ones that rely on exact timing. One is a set and a clear landing on the same sticky bit in the same cycle. Others are requests written during the transient stop and start phases, and read strobes that overlap control writes. A fixed-seed random stream produces these situations over thousands of cycles. It mixes writes to all four words, random acknowledges and sparse illegal-access bursts, and every output is compared each cycle against a model in the bench. Before the random phase, directed sequences force the ordered corner cases. These are a held-off stop acknowledge, repeated freeze requests while frozen, an unfreeze while running, both request bits written together, and a set-versus-clear collision.

// File: rtl/prr_pkg.sv
package prr_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_FROZEN = 2'd2,
        ST_START  = 2'd3
    } prr_state_e;

    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_STATUS  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL    = 2'd1;
    localparam logic [ADDR_W-1:0] A_ILLEGAL = 2'd2;
    localparam logic [ADDR_W-1:0] A_IEN     = 2'd3;

    localparam int unsigned CB_FREEZE   = 0;
    localparam int unsigned CB_UNFREEZE = 1;
    localparam int unsigned CB_RESET    = 2;

    localparam int unsigned SB_FROZEN  = 0;
    localparam int unsigned SB_RUNNING = 1;
    localparam int unsigned SB_BUSY    = 2;

endpackage

// File: rtl/prr_seq.sv
module prr_seq
    import prr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic freeze_cmd,
    input  logic unfreeze_cmd,
    input  logic reset_cmd,
    input  logic stop_ack,
    input  logic start_ack,
    output logic stop_req,
    output logic start_req,
    output logic frozen,
    output logic running,
    output logic busy,
    output logic region_rst
);

    typedef struct packed {
        prr_state_e st;
        logic       rrst;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.rrst = reset_cmd;
        unique case (seq_q.st)
            ST_RUN:    if (freeze_cmd)   seq_d.st = ST_STOP;
            ST_STOP:   if (stop_ack)     seq_d.st = ST_FROZEN;
            ST_FROZEN: if (unfreeze_cmd) seq_d.st = ST_START;
            ST_START:  if (start_ack)    seq_d.st = ST_RUN;
            default:                     seq_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st   <= ST_RUN;
            seq_q.rrst <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign stop_req   = (seq_q.st == ST_STOP);
    assign start_req  = (seq_q.st == ST_START);
    assign frozen     = (seq_q.st == ST_FROZEN);
    assign running    = (seq_q.st == ST_RUN);
    assign busy       = stop_req | start_req;
    assign region_rst = seq_q.rrst;

endmodule

// File: rtl/prr_flags.sv
module prr_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] illegal_in,
    input  logic [N-1:0] clr_mask,
    input  logic         ien_we,
    input  logic [N-1:0] ien_wdata,
    output logic [N-1:0] sticky,
    output logic [N-1:0] ien,
    output logic         irq
);

    typedef struct packed {
        logic [N-1:0] sticky;
        logic [N-1:0] ien;
    } flag_regs_t;

    flag_regs_t flg_d, flg_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // a new report outranks a clear aimed at the same bit
        always_comb begin
            flg_d.sticky[i] = (flg_q.sticky[i] & ~clr_mask[i]) | illegal_in[i];
            flg_d.ien[i]    = ien_we ? ien_wdata[i] : flg_q.ien[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign sticky = flg_q.sticky;
    assign ien    = flg_q.ien;
    assign irq    = |(flg_q.sticky & flg_q.ien);

endmodule

// File: rtl/prr_csr.sv
module prr_csr
    import prr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frozen,
    input  logic              running,
    input  logic              busy,
    input  logic [N-1:0]      sticky,
    input  logic [N-1:0]      ien,
    output logic              freeze_cmd,
    output logic              unfreeze_cmd,
    output logic              reset_cmd,
    output logic [N-1:0]      clr_mask,
    output logic              ien_we,
    output logic [N-1:0]      ien_wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } csr_regs_t;

    csr_regs_t csr_d, csr_q;

    logic wr_ctrl;

    always_comb begin
        wr_ctrl      = wr && (addr == A_CTRL);
        freeze_cmd   = wr_ctrl && wdata[CB_FREEZE];
        unfreeze_cmd = wr_ctrl && wdata[CB_UNFREEZE];
        reset_cmd    = wr_ctrl && wdata[CB_RESET];
        clr_mask     = (wr && (addr == A_ILLEGAL)) ? wdata[N-1:0] : '0;
        ien_we       = wr && (addr == A_IEN);
        ien_wdata    = wdata[N-1:0];
    end

    always_comb begin
        csr_d.rdata = '0;
        if (rd) begin
            unique case (addr)
                A_STATUS: begin
                    csr_d.rdata[SB_FROZEN]  = frozen;
                    csr_d.rdata[SB_RUNNING] = running;
                    csr_d.rdata[SB_BUSY]    = busy;
                end
                A_ILLEGAL: csr_d.rdata[N-1:0] = sticky;
                A_IEN:     csr_d.rdata[N-1:0] = ien;
                default:   csr_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q <= '0;
        end else begin
            csr_q <= csr_d;
        end
    end

    assign rdata = csr_q.rdata;

endmodule

// File: rtl/prr_freeze_ctrl.sv
module prr_freeze_ctrl
    import prr_pkg::*;
#(
    parameter int unsigned NUM_BRIDGES = 3,
    parameter int unsigned DATA_W      = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      csr_addr,
    input  logic                   csr_rd,
    input  logic                   csr_wr,
    input  logic [DATA_W-1:0]      csr_wdata,
    output logic [DATA_W-1:0]      csr_rdata,
    output logic                   irq,
    output logic                   stop_req,
    input  logic                   stop_ack,
    output logic                   start_req,
    input  logic                   start_ack,
    output logic                   region_rst,
    output logic                   frz_status,
    output logic                   unfrz_status,
    output logic [NUM_BRIDGES-1:0] bridge_freeze,
    input  logic [NUM_BRIDGES-1:0] bridge_illegal
);

    logic                   freeze_cmd, unfreeze_cmd, reset_cmd;
    logic                   frozen, running, busy;
    logic [NUM_BRIDGES-1:0] clr_mask, ien_wdata, sticky, ien;
    logic                   ien_we;

    prr_csr #(.DATA_W(DATA_W), .N(NUM_BRIDGES)) u_csr (
        .clk          (clk),
        .rst          (rst),
        .addr         (csr_addr),
        .rd           (csr_rd),
        .wr           (csr_wr),
        .wdata        (csr_wdata),
        .frozen       (frozen),
        .running      (running),
        .busy         (busy),
        .sticky       (sticky),
        .ien          (ien),
        .freeze_cmd   (freeze_cmd),
        .unfreeze_cmd (unfreeze_cmd),
        .reset_cmd    (reset_cmd),
        .clr_mask     (clr_mask),
        .ien_we       (ien_we),
        .ien_wdata    (ien_wdata),
        .rdata        (csr_rdata)
    );

    prr_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .freeze_cmd   (freeze_cmd),
        .unfreeze_cmd (unfreeze_cmd),
        .reset_cmd    (reset_cmd),
        .stop_ack     (stop_ack),
        .start_ack    (start_ack),
        .stop_req     (stop_req),
        .start_req    (start_req),
        .frozen       (frozen),
        .running      (running),
        .busy         (busy),
        .region_rst   (region_rst)
    );

    prr_flags #(.N(NUM_BRIDGES)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .illegal_in (bridge_illegal),
        .clr_mask   (clr_mask),
        .ien_we     (ien_we),
        .ien_wdata  (ien_wdata),
        .sticky     (sticky),
        .ien        (ien),
        .irq        (irq)
    );

    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_frz
        assign bridge_freeze[b] = frozen;
    end

    assign frz_status   = frozen;
    assign unfrz_status = running;

endmodule

// File: rtl/prr_freeze_checker.sv
module prr_freeze_checker #(
    parameter int unsigned N      = 3,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        csr_addr,
    input logic              csr_rd,
    input logic              csr_wr,
    input logic [DATA_W-1:0] csr_wdata,
    input logic [DATA_W-1:0] csr_rdata,
    input logic              irq,
    input logic              stop_req,
    input logic              stop_ack,
    input logic              start_req,
    input logic              start_ack,
    input logic              region_rst,
    input logic              frz_status,
    input logic              unfrz_status,
    input logic [N-1:0]      bridge_freeze,
    input logic [N-1:0]      bridge_illegal
);

    p_stop_hold_r2: assert property (@(posedge clk) disable iff (rst)
        stop_req && !stop_ack |=> stop_req && (bridge_freeze == '0));

    p_freeze_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bridge_freeze[0]) |-> $past(stop_req && stop_ack));

    p_no_freeze_with_start_r4: assert property (@(posedge clk) disable iff (rst)
        start_req |-> (bridge_freeze == '0) && !frz_status);

    p_start_from_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(start_req) |-> $past(frz_status));

    p_run_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
        start_req && start_ack |=> unfrz_status && !start_req);

    p_rst_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        region_rst |-> $past(csr_wr && (csr_addr == 2'd1) && csr_wdata[2]));

    p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past((|bridge_illegal) || (csr_wr && (csr_addr == 2'd3))));

    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !csr_rd |=> (csr_rdata == '0));

endmodule

bind prr_freeze_ctrl prr_freeze_checker #(.N(NUM_BRIDGES), .DATA_W(DATA_W)) u_prr_chk (
    .clk            (clk),
    .rst            (rst),
    .csr_addr       (csr_addr),
    .csr_rd         (csr_rd),
    .csr_wr         (csr_wr),
    .csr_wdata      (csr_wdata),
    .csr_rdata      (csr_rdata),
    .irq            (irq),
    .stop_req       (stop_req),
    .stop_ack       (stop_ack),
    .start_req      (start_req),
    .start_ack      (start_ack),
    .region_rst     (region_rst),
    .frz_status     (frz_status),
    .unfrz_status   (unfrz_status),
    .bridge_freeze  (bridge_freeze),
    .bridge_illegal (bridge_illegal)
);

// File: tb/test_prr_freeze_ctrl.sv
module test_prr_freeze_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    csr_addr = '0;
    logic          csr_rd = 1'b0;
    logic          csr_wr = 1'b0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic          irq, stop_req, start_req, region_rst, frz_status, unfrz_status;
    logic          stop_ack = 1'b0;
    logic          start_ack = 1'b0;
    logic [NB-1:0] bridge_freeze;
    logic [NB-1:0] bridge_illegal = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model: 0 running, 1 stopping, 2 frozen, 3 starting
    logic [1:0]    ms;
    logic [NB-1:0] msticky, mien;
    logic          mrst;
    logic [31:0]   mrdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    prr_freeze_ctrl #(.NUM_BRIDGES(NB), .DATA_W(32)) i_prr_freeze_ctrl (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq), .stop_req(stop_req),
        .stop_ack(stop_ack), .start_req(start_req), .start_ack(start_ack),
        .region_rst(region_rst), .frz_status(frz_status), .unfrz_status(unfrz_status),
        .bridge_freeze(bridge_freeze), .bridge_illegal(bridge_illegal)
    );

    function automatic logic [31:0] exp_rdata(logic [1:0] a, logic [1:0] s,
                                              logic [NB-1:0] st, logic [NB-1:0] en);
        logic [31:0] r = '0;
        case (a)
            2'd0: r[2:0] = {(s == 2'd1) || (s == 2'd3), s == 2'd0, s == 2'd2};
            2'd2: r[NB-1:0] = st;
            2'd3: r[NB-1:0] = en;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] exp_state(logic [1:0] s, logic fz, logic uf,
                                             logic sa, logic ga);
        case (s)
            2'd0: return fz ? 2'd1 : 2'd0;
            2'd1: return sa ? 2'd2 : 2'd1;
            2'd2: return uf ? 2'd3 : 2'd2;
            default: return ga ? 2'd0 : 2'd3;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] a, logic rd, logic wr, logic [31:0] wd,
                         logic sa, logic ga, logic [NB-1:0] il);
        csr_addr = a; csr_rd = rd; csr_wr = wr; csr_wdata = wd;
        stop_ack = sa; start_ack = ga; bridge_illegal = il;
    endtask

    task automatic idle();
        drive(2'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, '0);
    endtask

    // advance one clock from a negedge, update the model, compare at the next negedge
    task automatic step();
        logic          wc = csr_wr && (csr_addr == 2'd1);
        logic [1:0]    ns = exp_state(ms, wc && csr_wdata[0], wc && csr_wdata[1],
                                      stop_ack, start_ack);
        logic [NB-1:0] clr = (csr_wr && csr_addr == 2'd2) ? csr_wdata[NB-1:0] : '0;
        logic [31:0]   nrd = csr_rd ? exp_rdata(csr_addr, ms, msticky, mien) : 32'd0;
        logic [NB-1:0] nst = (msticky & ~clr) | bridge_illegal;
        logic [NB-1:0] nen = (csr_wr && csr_addr == 2'd3) ? csr_wdata[NB-1:0] : mien;
        @(posedge clk);
        @(negedge clk);
        ms = ns; msticky = nst; mien = nen; mrst = wc && csr_wdata[2]; mrdata = nrd;
        chk("R2 stop_req",     {31'd0, stop_req},     {31'd0, ms == 2'd1});
        chk("R3 freeze lines", {29'd0, bridge_freeze}, {29'd0, {NB{ms == 2'd2}}});
        chk("R3 frz_status",   {31'd0, frz_status},   {31'd0, ms == 2'd2});
        chk("R4 start_req",    {31'd0, start_req},    {31'd0, ms == 2'd3});
        chk("R5 unfrz_status", {31'd0, unfrz_status}, {31'd0, ms == 2'd0});
        chk("R7 region_rst",   {31'd0, region_rst},   {31'd0, mrst});
        chk("R9 irq",          {31'd0, irq},          {31'd0, |(msticky & mien)});
        chk("R10 rdata",       csr_rdata,             mrdata);
    endtask

    task automatic rd_word(logic [1:0] a);
        drive(a, 1'b1, 1'b0, 32'd0, 1'b0, 1'b0, '0);
        step();
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        ms = 2'd0; msticky = '0; mien = '0; mrst = 1'b0; mrdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 unfrz_status", {31'd0, unfrz_status}, 32'd1);
        chk("R1 outputs low", {26'd0, frz_status, stop_req, start_req, region_rst, irq, |bridge_freeze}, 32'd0);
        chk("R1 rdata", csr_rdata, 32'd0);

        // R2: freeze with acknowledge held off
        drive(2'd1, 1'b0, 1'b1, 32'h1, 1'b0, 1'b0, '0); step(); idle();
        repeat (3) step();
        chk("R2 held stop_req", {31'd0, stop_req}, 32'd1);
        chk("R2 freeze low while waiting", {29'd0, bridge_freeze}, 32'd0);
        rd_word(2'd0);
        chk("R11 busy while stopping", csr_rdata, 32'h4);

        // R3: acknowledge
        drive(2'd0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b0, '0); step(); idle();
        chk("R3 all frozen", {28'd0, stop_req, bridge_freeze}, {28'd0, 1'b0, {NB{1'b1}}});

        // R6: freeze while frozen is ignored
        drive(2'd1, 1'b0, 1'b1, 32'h1, 1'b1, 1'b0, '0); step(); idle(); step();
        chk("R6 freeze ignored when frozen", {30'd0, frz_status, stop_req}, 32'h2);
        rd_word(2'd0);
        chk("R11 idle when frozen", csr_rdata, 32'h1);

        // R4: unfreeze
        drive(2'd1, 1'b0, 1'b1, 32'h2, 1'b0, 1'b0, '0); step(); idle();
        chk("R4 freeze dropped, start raised", {28'd0, start_req, bridge_freeze}, 32'h8);
        rd_word(2'd1);
        chk("R10 word1 reads zero", csr_rdata, 32'd0);

        // R5: start acknowledge
        drive(2'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1, '0); step(); idle();
        chk("R5 running", {30'd0, unfrz_status, start_req}, 32'h2);

        // R6: unfreeze while running ignored
        drive(2'd1, 1'b0, 1'b1, 32'h2, 1'b0, 1'b1, '0); step(); idle(); step();
        chk("R6 unfreeze ignored when running", {30'd0, start_req, unfrz_status}, 32'h1);

        // R7: reset pulse
        drive(2'd1, 1'b0, 1'b1, 32'h4, 1'b0, 1'b0, '0); step(); idle();
        chk("R7 pulse high", {31'd0, region_rst}, 32'd1);
        step();
        chk("R7 pulse one cycle", {31'd0, region_rst}, 32'd0);

        // R8 / R9: sticky flags and interrupt
        drive(2'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 3'b010); step(); idle(); step();
        chk("R9 masked irq", {31'd0, irq}, 32'd0);
        rd_word(2'd2);
        chk("R8 sticky bit1", csr_rdata, 32'h2);
        drive(2'd3, 1'b0, 1'b1, 32'h2, 1'b0, 1'b0, '0); step(); idle();
        chk("R9 enabled irq", {31'd0, irq}, 32'd1);
        drive(2'd2, 1'b0, 1'b1, 32'h2, 1'b0, 1'b0, 3'b010); step(); idle();
        chk("R8 set beats clear", {31'd0, irq}, 32'd1);
        drive(2'd2, 1'b0, 1'b1, 32'h2, 1'b0, 1'b0, '0); step(); idle();
        chk("R8 cleared by write-one", {31'd0, irq}, 32'd0);
        rd_word(2'd3);
        chk("R10 enable readback", csr_rdata, 32'h2);

        // R6: both request bits while running, freeze wins
        drive(2'd1, 1'b0, 1'b1, 32'h3, 1'b0, 1'b0, '0); step(); idle();
        chk("R6 freeze wins", {30'd0, stop_req, start_req}, 32'h2);
        drive(2'd0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b0, '0); step();
        drive(2'd1, 1'b0, 1'b1, 32'h2, 1'b0, 1'b0, '0); step();
        drive(2'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1, '0); step(); idle();
        chk("R5 back to running", {31'd0, unfrz_status}, 32'd1);

        // random phase: every output compared with the model each cycle
        for (int n = 0; n < 4000; n++) begin
            logic [NB-1:0] il = (($urandom % 10) == 0) ? NB'($urandom) : '0;
            logic [31:0]   wd = $urandom;
            if (($urandom % 3) == 0) wd[1:0] = 2'b11;
            drive(2'($urandom), ($urandom % 3) == 0, ($urandom % 4) == 0, wd,
                  ($urandom % 3) == 0, ($urandom % 3) == 0, il);
            step();
        end
        idle();
        step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule